// File: doc/BRIEF.md
# Protection-entry configuration write legalizer

This block holds the 8-bit configuration byte and the extended-attribute bit (E) of every entry in a physical-memory protection unit, and filters each write to them. Writes come from two sources. The packed port writes one byte lane per entry, covering a run of consecutive entries, and always clears E. The per-entry port writes one entry: the configuration comes from the low byte of its data word and E from the top bit. Each byte passes through a legalization step before it is stored. That step masks bits that are not implemented and repairs encodings that are illegal or reserved. It also rejects the whole write when the entry is locked, or when lockdown would be broken.

Four control inputs steer the filtering: a lock bypass, a machine-mode lockdown flag, a coarse-granularity flag and an enable for the memory-type field. Any write cycle produces a one-cycle flush strobe so that cached translations can be dropped. Address registers and the address-matching logic sit elsewhere.

Configuration byte layout: R bit 0, W bit 1, X bit 2, A field bits 4:3 (0 off, 1 top-of-range, 2 four-byte naturally aligned, 3 power-of-two naturally aligned), memory-type field bits 6:5, L bit 7.

Top module: `pmpcfg_legalizer`

## Requirements
- R1: After reset every configuration byte, every E bit, the flush strobe and the indirect read word are zero.
- R2: A write to an entry whose stored L bit (bit 7) is 1 changes neither its byte nor its E bit, unless the lock bypass input is 1, in which case it is legalized and stored.
- R3: With lockdown 0 and the written E 0, a byte with R=0 and W=1 is stored with W cleared; with lockdown 1 or written E 1 the W bit is kept.
- R4: With the coarse-granularity flag set, a written A value of 2 is stored as 3; with the flag clear it is stored as written.
- R5: The memory-type field (bits 6:5) is stored as 0 when its enable is 0, and a written value of 3 is stored as 0 when enabled; other values are kept.
- R6: With bypass 0, lockdown 1, written E 0, written L 1, RWX not 111, and either X=1 or (W=1, R=0), the write is dropped and both byte and E keep their old values; with E 1 the same byte is accepted.
- R7: On the packed port, byte lane k (bits 8k+7:8k) targets entry base+k; lanes that land at or beyond the entry count are ignored, and each accepted lane stores E=0.
- R8: The per-entry port takes the configuration from data bits 7:0 and E from bit XLEN-1, ignoring the bits between; the indirect read returns the selected entry's byte in bits 7:0, its E in bit XLEN-1 and zero elsewhere.
- R9: The flush output is 1 in the cycle after any cycle with a write enable asserted on either port, and 0 after a cycle with neither.
- R10: When both ports address the same entry in one cycle, that entry takes only the per-entry write and the packed lane for it is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rlb_i | input | 1 | Lock bypass: allows writes to locked entries and lifts the lockdown veto |
| mml_i | input | 1 | Machine-mode lockdown flag |
| coarse_gran_i | input | 1 | Granularity above four bytes |
| mt_en_i | input | 1 | Memory-type field implemented |
| dir_we_i | input | 1 | Packed port write enable |
| dir_base_i | input | IDX_W | First entry written by lane 0 |
| dir_wdata_i | input | XLEN | Packed configuration bytes, one per lane |
| ind_we_i | input | 1 | Per-entry port write enable |
| ind_idx_i | input | IDX_W | Entry selected for write and read |
| ind_wdata_i | input | XLEN | Configuration in bits 7:0, E in bit XLEN-1 |
| ind_rdata_o | output | XLEN | Selected entry, same format as the write word |
| cfg_o | output | N_ENTRIES*8 | All stored configuration bytes, entry k at bits 8k+7:8k |
| e_o | output | N_ENTRIES | All stored E bits |
| flush_o | output | 1 | One-cycle translation flush strobe |

## Verification
A corrupted byte or E bit in any entry shows on cfg_o and e_o from the clock edge that stored it. The same value shows through the indirect read as soon as the index selects that entry, so the bench compares every entry after each write. A filter that lets a locked or vetoed write through, or that repairs the wrong field, changes the stored byte in that same cycle. A missing or stretched flush shows one cycle after the write enable.

// File: rtl/pmpcfg_pkg.sv
package pmpcfg_pkg;
  localparam int CFG_R     = 0;
  localparam int CFG_W     = 1;
  localparam int CFG_X     = 2;
  localparam int CFG_A_LO  = 3;
  localparam int CFG_A_HI  = 4;
  localparam int CFG_MT_LO = 5;
  localparam int CFG_MT_HI = 6;
  localparam int CFG_L     = 7;

  localparam logic [7:0] CFG_BASE_MASK = 8'h9F;
  localparam logic [7:0] CFG_MT_MASK   = 8'h60;

  typedef enum logic [1:0] {
    A_OFF   = 2'd0,
    A_TOR   = 2'd1,
    A_NA4   = 2'd2,
    A_NAPOT = 2'd3
  } addr_mode_e;

  localparam logic [1:0] MT_RSVD = 2'd3;
endpackage

// File: rtl/pmpcfg_legalize.sv
module pmpcfg_legalize
  import pmpcfg_pkg::*;
(
  input  logic       old_lock_i,
  input  logic [7:0] wr_cfg_i,
  input  logic       wr_e_i,
  input  logic       rlb_i,
  input  logic       mml_i,
  input  logic       coarse_i,
  input  logic       mt_en_i,
  output logic       accept_o,
  output logic [7:0] cfg_o
);
  logic [7:0] c;
  logic       veto;

  always_comb begin
    c = wr_cfg_i & (CFG_BASE_MASK | (mt_en_i ? CFG_MT_MASK : 8'h00));
    // write-only encoding is folded to no-access outside lockdown / E
    if (!mml_i && !wr_e_i && c[CFG_W] && !c[CFG_R]) c[CFG_W] = 1'b0;
    if (coarse_i && c[CFG_A_HI:CFG_A_LO] == A_NA4) c[CFG_A_HI:CFG_A_LO] = A_NAPOT;
    if (c[CFG_MT_HI:CFG_MT_LO] == MT_RSVD) c[CFG_MT_HI:CFG_MT_LO] = 2'd0;
    veto = !rlb_i && mml_i && !wr_e_i && c[CFG_L]
        && (c[CFG_X:CFG_R] != 3'b111)
        && (c[CFG_X] || (c[CFG_W] && !c[CFG_R]));
    accept_o = (rlb_i || !old_lock_i) && !veto;
    cfg_o    = c;
  end
endmodule

// File: rtl/pmpcfg_src_sel.sv
module pmpcfg_src_sel #(
  parameter int N_ENTRIES = 8,
  parameter int XLEN      = 32,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic                      dir_we_i,
  input  logic [IDX_W-1:0]          dir_base_i,
  input  logic [XLEN-1:0]           dir_wdata_i,
  input  logic                      ind_we_i,
  input  logic [IDX_W-1:0]          ind_idx_i,
  input  logic [XLEN-1:0]           ind_wdata_i,
  output logic [N_ENTRIES-1:0]      wr_en_o,
  output logic [N_ENTRIES-1:0][7:0] wr_cfg_o,
  output logic [N_ENTRIES-1:0]      wr_e_o
);
  localparam int LANES = XLEN / 8;
  localparam int LW    = $clog2(LANES);

  logic [LANES-1:0][7:0] dir_bytes;
  logic                  unused_mid;

  assign dir_bytes  = dir_wdata_i;
  assign unused_mid = ^ind_wdata_i[XLEN-2:8];

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    int          ofs;
    logic [LW-1:0] lane;
    logic        dir_hit;
    logic        ind_hit;

    always_comb begin
      ofs     = i - int'(dir_base_i);
      lane    = LW'(ofs);
      dir_hit = dir_we_i && (ofs >= 0) && (ofs < LANES);
      ind_hit = ind_we_i && (ind_idx_i == IDX_W'(i));
      wr_en_o[i]  = dir_hit || ind_hit;
      // per-entry port wins a collision
      wr_cfg_o[i] = ind_hit ? ind_wdata_i[7:0] : dir_bytes[lane];
      wr_e_o[i]   = ind_hit ? ind_wdata_i[XLEN-1] : 1'b0;
    end
  end
endmodule

// File: rtl/pmpcfg_entry.sv
module pmpcfg_entry (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] cfg_i,
  input  logic       e_i,
  output logic [7:0] cfg_o,
  output logic       e_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
      e_o   <= 1'b0;
    end else if (we_i) begin
      cfg_o <= cfg_i;
      e_o   <= e_i;
    end
  end
endmodule

// File: rtl/pmpcfg_legalizer.sv
module pmpcfg_legalizer
  import pmpcfg_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int XLEN      = 32,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rlb_i,
  input  logic                   mml_i,
  input  logic                   coarse_gran_i,
  input  logic                   mt_en_i,
  input  logic                   dir_we_i,
  input  logic [IDX_W-1:0]       dir_base_i,
  input  logic [XLEN-1:0]        dir_wdata_i,
  input  logic                   ind_we_i,
  input  logic [IDX_W-1:0]       ind_idx_i,
  input  logic [XLEN-1:0]        ind_wdata_i,
  output logic [XLEN-1:0]        ind_rdata_o,
  output logic [N_ENTRIES*8-1:0] cfg_o,
  output logic [N_ENTRIES-1:0]   e_o,
  output logic                   flush_o
);
  logic [N_ENTRIES-1:0]      wr_en;
  logic [N_ENTRIES-1:0][7:0] wr_cfg;
  logic [N_ENTRIES-1:0]      wr_e;
  logic [N_ENTRIES-1:0]      acc;
  logic [N_ENTRIES-1:0][7:0] leg_cfg;
  logic [N_ENTRIES-1:0][7:0] cfg_q;
  logic [N_ENTRIES-1:0]      e_q;
  logic                      flush_q;

  pmpcfg_src_sel #(.N_ENTRIES(N_ENTRIES), .XLEN(XLEN), .IDX_W(IDX_W)) u_sel (
    .dir_we_i   (dir_we_i),
    .dir_base_i (dir_base_i),
    .dir_wdata_i(dir_wdata_i),
    .ind_we_i   (ind_we_i),
    .ind_idx_i  (ind_idx_i),
    .ind_wdata_i(ind_wdata_i),
    .wr_en_o    (wr_en),
    .wr_cfg_o   (wr_cfg),
    .wr_e_o     (wr_e)
  );

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    pmpcfg_legalize u_leg (
      .old_lock_i(cfg_q[i][CFG_L]),
      .wr_cfg_i  (wr_cfg[i]),
      .wr_e_i    (wr_e[i]),
      .rlb_i     (rlb_i),
      .mml_i     (mml_i),
      .coarse_i  (coarse_gran_i),
      .mt_en_i   (mt_en_i),
      .accept_o  (acc[i]),
      .cfg_o     (leg_cfg[i])
    );

    pmpcfg_entry u_entry (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (wr_en[i] && acc[i]),
      .cfg_i (leg_cfg[i]),
      .e_i   (wr_e[i]),
      .cfg_o (cfg_q[i]),
      .e_o   (e_q[i])
    );

    assert_locked_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[i][CFG_L] && !rlb_i) |=> (cfg_q[i] == $past(cfg_q[i]) && e_q[i] == $past(e_q[i])));

    assert_wonly_fold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en[i] && acc[i] && !mml_i && !wr_e[i]) |=> !(cfg_q[i][CFG_W] && !cfg_q[i][CFG_R]));

    assert_na4_promote_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en[i] && acc[i] && coarse_gran_i) |=> (cfg_q[i][CFG_A_HI:CFG_A_LO] != A_NA4));

    assert_mt_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q[i][CFG_MT_HI:CFG_MT_LO] != MT_RSVD);

    assert_mt_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en[i] && acc[i] && !mt_en_i) |=> (cfg_q[i][CFG_MT_HI:CFG_MT_LO] == 2'd0));

    assert_lockdown_veto_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en[i] && !rlb_i && mml_i && !wr_e[i] && wr_cfg[i][CFG_L] && wr_cfg[i][CFG_X]
       && (wr_cfg[i][CFG_X:CFG_R] != 3'b111))
      |=> (cfg_q[i] == $past(cfg_q[i]) && e_q[i] == $past(e_q[i])));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else         flush_q <= dir_we_i || ind_we_i;
  end

  always_comb begin
    ind_rdata_o = '0;
    if (int'(ind_idx_i) < N_ENTRIES) begin
      ind_rdata_o[7:0]    = cfg_q[ind_idx_i];
      ind_rdata_o[XLEN-1] = e_q[ind_idx_i];
    end
  end

  assign cfg_o   = cfg_q;
  assign e_o     = e_q;
  assign flush_o = flush_q;

  assert_flush_on_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_we_i || ind_we_i) |=> flush_o);

  assert_flush_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dir_we_i || ind_we_i) |=> !flush_o);
endmodule

// File: tb/pmpcfg_legalizer_tb.sv
`timescale 1ns/1ps
module pmpcfg_legalizer_tb;
  localparam int N     = 8;
  localparam int XLEN  = 32;
  localparam int IDX_W = 3;
  localparam int LANES = XLEN / 8;
  localparam logic [3:0] F_RLB = 4'b1000, F_MML = 4'b0100, F_CRS = 4'b0010, F_MT = 4'b0001;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rlb_i = 0, mml_i = 0, coarse_gran_i = 0, mt_en_i = 0;
  logic dir_we_i = 0, ind_we_i = 0;
  logic [IDX_W-1:0] dir_base_i = '0, ind_idx_i = '0;
  logic [XLEN-1:0] dir_wdata_i = '0, ind_wdata_i = '0;
  logic [XLEN-1:0] ind_rdata_o;
  logic [N*8-1:0] cfg_o;
  logic [N-1:0] e_o;
  logic flush_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_cfg [N];
  logic       m_e   [N];

  always #10 clk = ~clk;

  pmpcfg_legalizer #(.N_ENTRIES(N), .XLEN(XLEN), .IDX_W(IDX_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .rlb_i(rlb_i), .mml_i(mml_i),
    .coarse_gran_i(coarse_gran_i), .mt_en_i(mt_en_i),
    .dir_we_i(dir_we_i), .dir_base_i(dir_base_i), .dir_wdata_i(dir_wdata_i),
    .ind_we_i(ind_we_i), .ind_idx_i(ind_idx_i), .ind_wdata_i(ind_wdata_i),
    .ind_rdata_o(ind_rdata_o), .cfg_o(cfg_o), .e_o(e_o), .flush_o(flush_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected result from the requirement text, in integer arithmetic
  function automatic logic [8:0] mdl_leg(input logic [7:0] old, input logic [7:0] raw,
                                         input logic e, input logic [3:0] f);
    int v, r, w, x, a, mt, l;
    logic ok;
    v  = int'(raw) % (f[0] ? 256 : 32) + (f[0] ? 0 : (int'(raw) / 128) * 128);
    r  = v % 2; w = (v / 2) % 2; x = (v / 4) % 2;
    a  = (v / 8) % 4; mt = (v / 32) % 4; l = v / 128;
    if (!f[2] && !e && w == 1 && r == 0) w = 0;
    if (f[1] && a == 2) a = 3;
    if (mt == 3) mt = 0;
    ok = f[3] || old < 8'd128;
    if (!f[3] && f[2] && !e && l == 1 && !(r == 1 && w == 1 && x == 1) && (x == 1 || (w == 1 && r == 0)))
      ok = 1'b0;
    return {ok, 8'(l * 128 + mt * 32 + a * 8 + x * 4 + w * 2 + r)};
  endfunction

  task automatic mdl_apply(input int ent, input logic [7:0] raw, input logic e, input logic [3:0] f);
    logic [8:0] res;
    res = mdl_leg(m_cfg[ent], raw, e, f);
    if (res[8]) begin
      m_cfg[ent] = res[7:0];
      m_e[ent]   = e;
    end
  endtask

  task automatic compare_all(input string req);
    logic [N*8-1:0] exp_cfg;
    logic [N-1:0]   exp_e;
    for (int k = 0; k < N; k++) begin
      exp_cfg[8*k +: 8] = m_cfg[k];
      exp_e[k] = m_e[k];
    end
    chk(req, 64'(cfg_o), 64'(exp_cfg));
    chk(req, 64'(e_o), 64'(exp_e));
  endtask

  task automatic readback_all();
    for (int k = 0; k < N; k++) begin
      logic [XLEN-1:0] exp_rd;
      ind_idx_i = IDX_W'(k);
      #1;
      exp_rd = '0;
      exp_rd[7:0] = m_cfg[k];
      exp_rd[XLEN-1] = m_e[k];
      chk("R8 readback", 64'(ind_rdata_o), 64'(exp_rd));
    end
  endtask

  task automatic do_write(input logic dwe, input int base, input logic [XLEN-1:0] dwd,
                          input logic iwe, input int idx, input logic [XLEN-1:0] iwd,
                          input logic [3:0] f, input string req, input logic rb);
    @(negedge clk);
    chk("R9 idle", 64'(flush_o), 64'd0);
    rlb_i = f[3]; mml_i = f[2]; coarse_gran_i = f[1]; mt_en_i = f[0];
    dir_we_i = dwe; dir_base_i = IDX_W'(base); dir_wdata_i = dwd;
    ind_we_i = iwe; ind_idx_i = IDX_W'(idx); ind_wdata_i = iwd;
    for (int k = 0; k < LANES; k++)
      if (dwe && base + k < N && !(iwe && base + k == idx))
        mdl_apply(base + k, dwd[8*k +: 8], 1'b0, f);
    if (iwe) mdl_apply(idx, iwd[7:0], iwd[XLEN-1], f);
    @(negedge clk);
    chk("R9 pulse", 64'(flush_o), 64'(dwe | iwe));
    dir_we_i = 1'b0; ind_we_i = 1'b0;
    compare_all(req);
    if (rb) readback_all();
  endtask

  task automatic iwr(input int idx, input logic e, input logic [7:0] c, input logic [3:0] f, input string req);
    logic [XLEN-1:0] d;
    d = {e, 23'h2A5A5A, c};
    do_write(1'b0, 0, '0, 1'b1, idx, d, f, req, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin m_cfg[k] = '0; m_e[k] = 1'b0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cfg", 64'(cfg_o), 64'd0);
    chk("R1 e", 64'(e_o), 64'd0);
    chk("R1 flush", 64'(flush_o), 64'd0);
    chk("R1 rdata", 64'(ind_rdata_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R8 format, middle bits ignored
    iwr(2, 1'b1, 8'h0B, 4'b0000, "R8");
    ind_idx_i = 3'd2; #1;
    chk("R8 rdata", 64'(ind_rdata_o), 64'h8000_000B);

    // R3 write-only fold
    iwr(3, 1'b0, 8'h02, 4'b0000, "R3");
    chk("R3 fold", 64'(cfg_o[8*3 +: 8]), 64'h00);
    iwr(3, 1'b1, 8'h02, 4'b0000, "R3");
    chk("R3 kept E", 64'(cfg_o[8*3 +: 8]), 64'h02);
    iwr(3, 1'b0, 8'h02, F_MML, "R3");
    chk("R3 kept mml", 64'(cfg_o[8*3 +: 8]), 64'h02);

    // R4 granularity promotion
    iwr(1, 1'b0, 8'h11, F_CRS, "R4");
    chk("R4 promote", 64'(cfg_o[8*1 +: 8]), 64'h19);
    iwr(1, 1'b0, 8'h11, 4'b0000, "R4");
    chk("R4 keep", 64'(cfg_o[8*1 +: 8]), 64'h11);

    // R5 memory-type field
    iwr(0, 1'b0, 8'h41, 4'b0000, "R5");
    chk("R5 masked", 64'(cfg_o[7:0]), 64'h01);
    iwr(0, 1'b0, 8'h61, F_MT, "R5");
    chk("R5 reserved", 64'(cfg_o[7:0]), 64'h01);
    iwr(0, 1'b0, 8'h41, F_MT, "R5");
    chk("R5 legal", 64'(cfg_o[7:0]), 64'h41);

    // R6 lockdown veto
    iwr(4, 1'b0, 8'h84, F_MML, "R6");
    chk("R6 veto", 64'(cfg_o[8*4 +: 8]), 64'h00);
    iwr(4, 1'b1, 8'h84, F_MML, "R6");
    chk("R6 E exempt", 64'(cfg_o[8*4 +: 8]), 64'h84);
    chk("R6 E stored", 64'(e_o[4]), 64'd1);
    iwr(5, 1'b0, 8'h87, F_MML, "R6");
    chk("R6 rwx ok", 64'(cfg_o[8*5 +: 8]), 64'h87);

    // R2 lock and bypass
    iwr(4, 1'b0, 8'h01, 4'b0000, "R2");
    chk("R2 locked", 64'(cfg_o[8*4 +: 8]), 64'h84);
    chk("R2 locked e", 64'(e_o[4]), 64'd1);
    iwr(4, 1'b0, 8'h01, F_RLB, "R2");
    chk("R2 bypass", 64'(cfg_o[8*4 +: 8]), 64'h01);
    chk("R2 bypass e", 64'(e_o[4]), 64'd0);

    // R7 packed lanes past the end, E cleared
    iwr(6, 1'b1, 8'h01, 4'b0000, "R7");
    do_write(1'b1, 6, 32'h0D0C_0B09, 1'b0, 0, '0, 4'b0000, "R7", 1'b1);
    chk("R7 lane0", 64'(cfg_o[8*6 +: 8]), 64'h09);
    chk("R7 lane1", 64'(cfg_o[8*7 +: 8]), 64'h0B);
    chk("R7 e clr", 64'(e_o[6]), 64'd0);

    // R10 collision
    do_write(1'b1, 0, 32'h1B1A_1918, 1'b1, 1, 32'h8000_0003, 4'b0000, "R10", 1'b1);
    chk("R10 ind wins", 64'(cfg_o[8*1 +: 8]), 64'h03);
    chk("R10 ind e", 64'(e_o[1]), 64'd1);
    chk("R10 lane0", 64'(cfg_o[7:0]), 64'h18);

    // exhaustive byte x control x E sweep on the per-entry port
    for (int v = 0; v < 256; v++)
      for (int f = 0; f < 16; f++)
        for (int e = 0; e < 2; e++)
          do_write(1'b0, 0, '0, 1'b1, int'($urandom_range(N - 1, 0)),
                   {e[0], 23'($urandom), v[7:0]}, f[3:0], "R2 R3 R4 R5 R6 sweep", 1'b0);

    // mixed traffic on both ports
    for (int t = 0; t < 2500; t++) begin
      logic dwe, iwe;
      dwe = $urandom_range(1, 0) == 1;
      iwe = !dwe || ($urandom_range(3, 0) == 0);
      do_write(dwe, int'($urandom_range(N - 1, 0)), 32'($urandom), iwe,
               int'($urandom_range(N - 1, 0)), 32'($urandom), 4'($urandom),
               "R7 R10 mixed", (t % 16) == 0);
    end

    @(negedge clk);
    chk("R9 final idle", 64'(flush_o), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule